// File: doc/BRIEF.md
# Multiplexed Flash Bus Controller

This block turns single requests from an internal port (address, write data, byte enables, direction, valid/ready) into accesses on an external peripheral bus. That bus shares its low sixteen lines between address and data and serves 8-bit or 16-bit flash parts. The address space holds two windows, and each window has its own active-low chip enable and its own pair of wait-state counts. Window 0 comes out of reset enabled with the slowest timing, so the system can boot from it whatever the speed of the part.

Every accepted access runs the same sequence. The address goes out on the shared lines with a one-cycle latch strobe. The address is held for one more cycle. Output enable (reads) or write enable (writes) is then held low for the programmed address-to-data count. The data is sampled or held during that time. After that come a single response cycle and the programmed number of recovery cycles. A strap input, latched while reset is high, sets the data width. A request that hits no enabled window, or a write that does not fit in one bus data cycle, is answered with an error and never reaches the bus.

A separate configuration port writes the counts and the enable bit of each window. Each count is 4 bits, and one wait state is one clock of 15 ns at 66 MHz. The recommended profiles are (4 data waits, 0 recovery) for parts of 55 ns or less, (8, 2) for 115 ns or less and (10, 2) for 150 ns or less.

Top module: `mflash_bus_ctrl`

## Requirements
- R1: Window i covers addresses whose bits [23:22] equal i (window 0 at 0x000000–0x3FFFFF, window 1 at 0x400000–0x7FFFFF). Bus chip enable bit i goes low only during an access to window i, and the two bits are never low together.
- R2: After reset, window 0 is enabled with 15 address-to-data waits and 3 recovery cycles, and window 1 is disabled. All bus strobes are inactive: chip enables 2'b11, latch strobe low, output and write enables high, and the ready output is low.
- R3: The bus width is 16 bits when strap_wide is 1 and 8 bits when it is 0. The strap is sampled only while rst is high, so changing it afterwards has no effect.
- R4: A configuration write (cfg_we high for one clock) sets the enable, address-to-data count and recovery count of window cfg_win. Counts are taken when a request is accepted, so a request accepted in the same clock as a configuration write uses the old values. An address-to-data count of 0 behaves as 1.
- R5: An accepted access first drives the address on fb_ad_out[15:0] and fb_addr_hi with fb_ad_oe high and fb_ale high for exactly one cycle. In the next cycle fb_ale is low and the address is still driven. The data phase starts only after that.
- R6: The data phase lasts N cycles, where N is the window's address-to-data count. For a read, fb_oe_n is low and fb_ad_oe is low, and rsp_rdata takes fb_ad_in from the last data cycle: all 16 bits on a 16-bit bus, the low byte zero-extended on an 8-bit bus. For a write, fb_we_n is low and fb_ad_out carries the data.
- R7: For a write on an 8-bit bus, fb_ad_out[7:0] carries req_wdata[15:8] when req_be is 2'b10 and req_wdata[7:0] otherwise. The upper bits are 0.
- R8: After the data phase there is one response cycle, then M recovery cycles, where M is the window's recovery count. Chip enables are all high in both. A request is accepted at the earliest in the clock after the last recovery cycle.
- R9: req_ready is high for exactly one cycle per request. For a request accepted at clock t, it is high in cycle t+N+3. rsp_err is 0 on a completed access.
- R10: A write with req_be of 2'b00, or with req_be of 2'b11 on an 8-bit bus, is answered in the next cycle with req_ready and rsp_err high. No chip enable, latch strobe or write enable is asserted for it.
- R11: A request to an address outside both windows, or inside a disabled window, is answered in the next cycle with rsp_err high and asserts no chip enable.
- R12: Each recommended profile, (4,0), (8,2) and (10,2), gives exactly N data cycles and M recovery cycles. A back-to-back request made right after the response therefore sees its ready M+N+3 cycles after it was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one wait state per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| strap_wide | input | 1 | Bus width strap, 1 = 16-bit, latched during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 1 | Window selected by a configuration write |
| cfg_en | input | 1 | Window enable value to write |
| cfg_a2d | input | 4 | Address-to-data wait count to write |
| cfg_rec | input | 4 | Recovery wait count to write |
| req_valid | input | 1 | Request valid, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_be | input | 2 | Byte enables of the write |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with req_ready |
| rsp_rdata | output | 16 | Read data, valid with req_ready |
| fb_ce_n | output | 2 | Active-low chip enable per window |
| fb_ale | output | 1 | Address latch strobe |
| fb_oe_n | output | 1 | Active-low output enable |
| fb_we_n | output | 1 | Active-low write enable |
| fb_ad_out | output | 16 | Value driven on the shared address/data lines |
| fb_ad_oe | output | 1 | Drive enable for the shared lines |
| fb_ad_in | input | 16 | Value read from the shared lines |
| fb_addr_hi | output | 8 | Upper address bits, valid with the address phase |

## Verification
A configuration write and the acceptance of a request can land on the same clock edge. The bench provokes this by raising cfg_we and req_valid together while the controller is idle, with a new count for the window being read. It then judges by the length of the output-enable phase and the ready latency that the old counts applied to that access and the new ones to the next. A second overlap is a request waiting while recovery is still running. Requests are issued back to back straight after each response, and the ready latency must include exactly the previous access's recovery count.

// File: rtl/mflash_pkg.sv
package mflash_pkg;
  localparam int CNT_W  = 4;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHOLD,
    ST_DATA,
    ST_END,
    ST_RECOV
  } seq_state_e;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] a2d;
    logic [CNT_W-1:0] rec;
  } win_cfg_t;
endpackage

// File: rtl/mflash_cfg_regs.sv
module mflash_cfg_regs
  import mflash_pkg::*;
#(
  parameter int NWIN     = 2,
  parameter int WSEL_W   = 1,
  parameter int BOOT_REC = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [WSEL_W-1:0]      cfg_win,
  input  logic                   cfg_en,
  input  logic [CNT_W-1:0]       cfg_a2d,
  input  logic [CNT_W-1:0]       cfg_rec,
  output win_cfg_t [NWIN-1:0]    cfgs
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < NWIN; i++) begin
      if (rst) begin
        cfgs[i].en  <= (i == 0);
        cfgs[i].a2d <= '1;
        cfgs[i].rec <= CNT_W'(BOOT_REC);
      end else if (cfg_we && (cfg_win == WSEL_W'(i))) begin
        cfgs[i].en  <= cfg_en;
        cfgs[i].a2d <= cfg_a2d;
        cfgs[i].rec <= cfg_rec;
      end
    end
  end
endmodule

// File: rtl/mflash_decode.sv
module mflash_decode
  import mflash_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 22,
  parameter int NWIN     = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  win_cfg_t [NWIN-1:0] cfgs,
  output logic [NWIN-1:0]     hit,
  output logic                hit_any,
  output logic [CNT_W-1:0]    sel_a2d,
  output logic [CNT_W-1:0]    sel_rec
);
  localparam int REG_W = ADDR_W - WIN_LOG2;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign hit[i] = cfgs[i].en && (addr[ADDR_W-1:WIN_LOG2] == REG_W'(i));
  end

  assign hit_any = |hit;

  always_comb begin
    sel_a2d = '0;
    sel_rec = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (hit[i]) begin
        sel_a2d = sel_a2d | cfgs[i].a2d;
        sel_rec = sel_rec | cfgs[i].rec;
      end
    end
  end
endmodule

// File: rtl/mflash_seq.sv
module mflash_seq
  import mflash_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NWIN   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wide,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [NWIN-1:0]   hit,
  input  logic              hit_any,
  input  logic [CNT_W-1:0]  sel_a2d,
  input  logic [CNT_W-1:0]  sel_rec,
  output logic              req_ready,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic [NWIN-1:0]   ce_n,
  output logic              ale,
  output logic              oe_n,
  output logic              we_n,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  input  logic [BUS_W-1:0]  ad_in,
  output logic [ADDR_W-BUS_W-1:0] addr_hi
);
  localparam int HI_W = ADDR_W - BUS_W;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, rec_q, rec_d;
  logic              wr_q, wr_d, err_q, err_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_W-1:0]  wdat_q, wdat_d, wfmt;
  logic [NWIN-1:0]   win_q, win_d;
  logic              legal_wr, start_ok;

  // a write must fit in a single bus data cycle
  assign legal_wr = (req_be != 2'b00) && (bus_wide || (req_be != 2'b11));
  assign start_ok = hit_any && (!req_write || legal_wr);

  always_comb begin
    if (bus_wide) begin
      wfmt = req_wdata;
    end else if (req_be == 2'b10) begin
      wfmt = {{(BUS_W-BYTE_W){1'b0}}, req_wdata[BUS_W-1:BYTE_W]};
    end else begin
      wfmt = {{(BUS_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rec_d   = rec_q;
    wr_d    = wr_q;
    err_d   = err_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    win_d   = win_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (start_ok) begin
            state_d = ST_ADDR;
            wr_d    = req_write;
            addr_d  = req_addr;
            wdat_d  = wfmt;
            win_d   = hit;
            err_d   = 1'b0;
            rec_d   = sel_rec;
            cnt_d   = (sel_a2d == '0) ? '0 : sel_a2d - 1'b1;
          end else begin
            state_d = ST_END;
            err_d   = 1'b1;
            rec_d   = '0;
            win_d   = '0;
            wr_d    = 1'b0;
          end
        end
      end
      ST_ADDR:  state_d = ST_AHOLD;
      ST_AHOLD: state_d = ST_DATA;
      ST_DATA: begin
        if (cnt_q == '0) state_d = ST_END;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_END: begin
        if (rec_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RECOV;
          cnt_d   = rec_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state and pins are registered together from the next-state values
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rec_q     <= '0;
      wr_q      <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      wdat_q    <= '0;
      win_q     <= '0;
      ce_n      <= '1;
      ale       <= 1'b0;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      ad_oe     <= 1'b0;
      ad_out    <= '0;
      addr_hi   <= '0;
      req_ready <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      rec_q     <= rec_d;
      wr_q      <= wr_d;
      err_q     <= err_d;
      addr_q    <= addr_d;
      wdat_q    <= wdat_d;
      win_q     <= win_d;
      ce_n      <= (state_d inside {ST_ADDR, ST_AHOLD, ST_DATA}) ? ~win_d : '1;
      ale       <= (state_d == ST_ADDR);
      oe_n      <= !((state_d == ST_DATA) && !wr_d);
      we_n      <= !((state_d == ST_DATA) && wr_d);
      ad_oe     <= (state_d inside {ST_ADDR, ST_AHOLD}) || ((state_d == ST_DATA) && wr_d);
      ad_out    <= ((state_d == ST_DATA) && wr_d) ? wdat_d : addr_d[BUS_W-1:0];
      addr_hi   <= addr_d[ADDR_W-1:BUS_W];
      req_ready <= (state_d == ST_END);
      rsp_err   <= (state_d == ST_END) && err_d;
    end
  end

  // read data is taken in the last cycle of the output-enable phase
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
    end else if ((state_q == ST_DATA) && (cnt_q == '0) && !wr_q) begin
      rsp_rdata <= bus_wide ? ad_in : {{(BUS_W-BYTE_W){1'b0}}, ad_in[BYTE_W-1:0]};
    end
  end

  assert_ce_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ce_n));

  assert_ale_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  assert_hold_before_data_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe_n) || $fell(we_n)) |-> $past(ad_oe && !ale && (ce_n != '1)));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  assert_recov_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECOV || req_ready) |-> ((ce_n == '1) && oe_n && we_n));

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  assert_err_no_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (req_ready && rsp_err) |-> ($past(ce_n == '1) && $past(!ale) && $past(we_n)));
endmodule

// File: rtl/mflash_bus_ctrl.sv
module mflash_bus_ctrl
  import mflash_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 22,
  parameter int NWIN     = 2,
  parameter int BOOT_REC = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strap_wide,
  input  logic                    cfg_we,
  input  logic [((NWIN > 1) ? $clog2(NWIN) : 1)-1:0] cfg_win,
  input  logic                    cfg_en,
  input  logic [CNT_W-1:0]        cfg_a2d,
  input  logic [CNT_W-1:0]        cfg_rec,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_be,
  input  logic [BUS_W-1:0]        req_wdata,
  output logic                    req_ready,
  output logic                    rsp_err,
  output logic [BUS_W-1:0]        rsp_rdata,
  output logic [NWIN-1:0]         fb_ce_n,
  output logic                    fb_ale,
  output logic                    fb_oe_n,
  output logic                    fb_we_n,
  output logic [BUS_W-1:0]        fb_ad_out,
  output logic                    fb_ad_oe,
  input  logic [BUS_W-1:0]        fb_ad_in,
  output logic [ADDR_W-BUS_W-1:0] fb_addr_hi
);
  localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  win_cfg_t [NWIN-1:0] cfgs;
  logic [NWIN-1:0]     hit;
  logic                hit_any;
  logic [CNT_W-1:0]    sel_a2d, sel_rec;
  logic                bus_wide_q;

  // width strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) bus_wide_q <= strap_wide;
  end

  mflash_cfg_regs #(.NWIN(NWIN), .WSEL_W(WSEL_W), .BOOT_REC(BOOT_REC)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_en(cfg_en), .cfg_a2d(cfg_a2d), .cfg_rec(cfg_rec), .cfgs(cfgs)
  );

  mflash_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NWIN(NWIN)) u_dec (
    .addr(req_addr), .cfgs(cfgs), .hit(hit), .hit_any(hit_any),
    .sel_a2d(sel_a2d), .sel_rec(sel_rec)
  );

  mflash_seq #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_seq (
    .clk(clk), .rst(rst), .bus_wide(bus_wide_q),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .hit(hit), .hit_any(hit_any), .sel_a2d(sel_a2d), .sel_rec(sel_rec),
    .req_ready(req_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ce_n(fb_ce_n), .ale(fb_ale), .oe_n(fb_oe_n), .we_n(fb_we_n),
    .ad_out(fb_ad_out), .ad_oe(fb_ad_oe), .ad_in(fb_ad_in), .addr_hi(fb_addr_hi)
  );
endmodule

// File: tb/mflash_bus_ctrl_test.sv
module mflash_bus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_wide = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_win = '0;
  logic        cfg_en = 1'b0;
  logic [3:0]  cfg_a2d = '0, cfg_rec = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_err;
  logic [15:0] rsp_rdata;
  logic [1:0]  fb_ce_n;
  logic        fb_ale, fb_oe_n, fb_we_n, fb_ad_oe;
  logic [15:0] fb_ad_out;
  logic [15:0] fb_ad_in = 16'hDEAD;
  logic [7:0]  fb_addr_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mflash_bus_ctrl uut (
    .clk(clk), .rst(rst), .strap_wide(strap_wide),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_en(cfg_en), .cfg_a2d(cfg_a2d), .cfg_rec(cfg_rec),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .fb_ce_n(fb_ce_n), .fb_ale(fb_ale), .fb_oe_n(fb_oe_n), .fb_we_n(fb_we_n),
    .fb_ad_out(fb_ad_out), .fb_ad_oe(fb_ad_oe), .fb_ad_in(fb_ad_in), .fb_addr_hi(fb_addr_hi)
  );

  task automatic check_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst = 1'b1;
    strap_wide = wide;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic w, input logic en, input logic [3:0] a2d, input logic [3:0] rec);
    cfg_win = w; cfg_en = en; cfg_a2d = a2d; cfg_rec = rec; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access, called at a negedge; returns at the negedge after the response
  task automatic access(input bit wr, input logic [23:0] a, input logic [1:0] be,
                        input logic [15:0] wd, input logic [15:0] src,
                        input int n_exp, input int m_prev, input bit err_exp,
                        input logic [1:0] ce_exp, input logic [15:0] data_exp,
                        input string tag);
    int cyc = 0;
    int n_ale = 0;
    int n_strb = 0;
    logic [1:0] ce_seen = '0;
    bit hold_ok = 1'b1;
    bit prev_ale = 1'b0;
    bit done = 1'b0;
    logic [15:0] wseen = '0;
    logic [15:0] ale_lo = '0;
    logic [7:0]  ale_hi = '0;
    req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      cfg_we = 1'b0;
      ce_seen = ce_seen | ~fb_ce_n;
      if (prev_ale) hold_ok = hold_ok && fb_ad_oe && !fb_ale && (fb_ad_out == a[15:0]);
      prev_ale = fb_ale;
      if (fb_ale) begin
        n_ale++;
        ale_lo = fb_ad_out;
        ale_hi = fb_addr_hi;
        hold_ok = hold_ok && fb_ad_oe;
      end
      if (!fb_oe_n || !fb_we_n) n_strb++;
      if (!fb_we_n) wseen = fb_ad_out;
      fb_ad_in = (!fb_oe_n && n_strb == n_exp) ? src : 16'hDEAD;
      if (req_ready) done = 1'b1;
    end
    check_eq({tag, " R9 ready latency"}, cyc, m_prev + (err_exp ? 1 : n_exp + 3));
    check_eq({tag, " R9/R10/R11 error flag"}, rsp_err, err_exp);
    check_eq({tag, " R1 chip enables used"}, ce_seen, ce_exp);
    check_eq({tag, " R5 latch strobes"}, n_ale, err_exp ? 0 : 1);
    check_eq({tag, " R6 strobe cycles"}, n_strb, err_exp ? 0 : n_exp);
    if (!err_exp) begin
      check_eq({tag, " R5 address phase"}, {ale_hi, ale_lo}, a);
      check_eq({tag, " R5 address hold"}, hold_ok, 1);
      if (wr) check_eq({tag, " R6/R7 write data"}, wseen, data_exp);
      else    check_eq({tag, " R6 read data"}, rsp_rdata, data_exp);
    end
    @(negedge clk);
    req_valid = 1'b0;
    fb_ad_in = 16'hDEAD;
    check_eq({tag, " R9 ready one cycle"}, req_ready, 0);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    check_eq("R2 idle chip enables", fb_ce_n, 2'b11);
    check_eq("R2 idle strobes", {fb_ale, fb_oe_n, fb_we_n}, 3'b011);
    check_eq("R2 ready low", req_ready, 0);
  endtask

  task automatic t_boot();
    access(0, 24'h001234, 2'b11, 0, 16'hA55A, 15, 0, 0, 2'b01, 16'hA55A, "R2 boot read");
    access(0, 24'h002000, 2'b11, 0, 16'h3C3C, 15, 3, 0, 2'b01, 16'h3C3C, "R8 boot b2b");
    idle(5);
  endtask

  task automatic t_profiles();
    int pa[3] = '{4, 8, 10};
    int pr[3] = '{0, 2, 2};
    for (int p = 0; p < 3; p++) begin
      cfg(0, 1, 4'(pa[p]), 4'(pr[p]));
      idle(2);
      access(0, 24'h000010, 2'b11, 0, 16'h1111 * 16'(p + 1), pa[p], 0, 0, 2'b01,
             16'h1111 * 16'(p + 1), "R12 profile");
      access(0, 24'h000020, 2'b11, 0, 16'h0F0F, pa[p], pr[p], 0, 2'b01, 16'h0F0F,
             "R12 profile b2b");
      idle(4);
    end
  endtask

  task automatic t_race();
    // config write and request acceptance in the same clock
    cfg_win = 1'b0; cfg_en = 1'b1; cfg_a2d = 4'd5; cfg_rec = 4'd1; cfg_we = 1'b1;
    access(0, 24'h000300, 2'b11, 0, 16'h7E7E, 10, 0, 0, 2'b01, 16'h7E7E, "R4 race old counts");
    access(0, 24'h000302, 2'b11, 0, 16'h8181, 5, 2, 0, 2'b01, 16'h8181, "R4 race new counts");
    idle(3);
  endtask

  task automatic t_zero();
    cfg(0, 1, 4'd0, 4'd0);
    idle(2);
    access(0, 24'h000040, 2'b11, 0, 16'h4242, 1, 0, 0, 2'b01, 16'h4242, "R4 zero count");
  endtask

  task automatic t_win1();
    access(0, 24'h400010, 2'b11, 0, 16'h0, 0, 0, 1, 2'b00, 16'h0, "R11 disabled window");
    cfg(1, 1, 4'd3, 4'd1);
    idle(2);
    access(0, 24'h4000F0, 2'b11, 0, 16'h9A9A, 3, 0, 0, 2'b10, 16'h9A9A, "R1 window1 read");
    access(0, 24'h800000, 2'b11, 0, 16'h0, 0, 1, 1, 2'b00, 16'h0, "R11 unmapped");
  endtask

  task automatic t_write16();
    cfg(0, 1, 4'd4, 4'd0);
    idle(2);
    access(1, 24'h000100, 2'b11, 16'h1357, 0, 4, 0, 0, 2'b01, 16'h1357, "R6 halfword write");
    access(1, 24'h000101, 2'b01, 16'h0024, 0, 4, 0, 0, 2'b01, 16'h0024, "R6 byte write");
  endtask

  task automatic t_narrow();
    do_reset(1'b0);
    strap_wide = 1'b1;  // must be ignored after reset (R3)
    cfg(0, 1, 4'd2, 4'd0);
    idle(2);
    access(1, 24'h000200, 2'b11, 16'hCAFE, 0, 0, 0, 1, 2'b00, 0, "R10 R3 wide write on 8-bit");
    access(1, 24'h000200, 2'b00, 16'hCAFE, 0, 0, 0, 1, 2'b00, 0, "R10 empty write");
    access(1, 24'h000201, 2'b10, 16'hAB12, 0, 2, 0, 0, 2'b01, 16'h00AB, "R7 upper lane");
    access(1, 24'h000200, 2'b01, 16'hAB12, 0, 2, 0, 0, 2'b01, 16'h0012, "R7 lower lane");
    access(0, 24'h000202, 2'b01, 0, 16'hBEEF, 2, 0, 0, 2'b01, 16'h00EF, "R3 R6 narrow read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_boot();
    t_profiles();
    t_race();
    t_zero();
    t_win1();
    t_write16();
    t_narrow();
    idle(2);
    summary();
    $finish;
  end
endmodule